// File: doc/BRIEF.md
# Dual Capture Channel Timer for Pulse Measurement

This block holds two capture channels that share one free-running up-counter. Each channel watches a selectable input pin, either its own or its partner's, for a rising or a falling edge. When that edge arrives, the channel copies the counter into its capture register and raises its event flag. If the flag is still set when the next capture lands, an overcapture flag is raised as well. The interrupt and DMA request lines of each channel follow its flag, and each line has its own enable.

The counter can be set to clear itself on the capture event of a chosen channel. For a PWM signal on pin 0, channel 0 captures rising edges of pin 0 and clears the counter. Channel 1 captures falling edges of the same pin. After one pass of the signal, channel 0 then holds the period and channel 1 the high time. Software can also raise a channel flag on its own through a generate pulse. Every control field is a plain input port, and both capture values are plain output ports.

Top module: `tmr_cap_pair`

## Requirements
- R1: After reset, `count`, both capture values, both flags, both overcapture flags, `irq` and `dma_req` are all zero.
- R2: While `cnt_en` is 1, `count` rises by one on each clock. When it equals `reload_val`, the next value is 0. While `cnt_en` is 0, `count` holds its value.
- R3: When `restart_en` is 1, a capture event on the channel named by `restart_src` (0 or 1) makes `count` 0 on the next clock. This takes priority over the increment and the wrap, and it applies even while `cnt_en` is 0.
- R4: Source select per channel: 2'b01 takes the channel's own pin, and 2'b10 takes the other channel's pin. 2'b00 and 2'b11 give no capture events.
- R5: `edge_pol` bit c is 0 for a rising-edge capture and 1 for a falling-edge capture. A pin level first seen at clock edge k loads the capture register at edge k+2. The value loaded is the `count` value present just before edge k+2.
- R6: A capture event loads the counter into that channel's capture register and sets its flag. Without a capture event the capture register keeps its value.
- R7: A capture event that finds the channel flag already set also sets the overcapture flag. `ovr_clr` bit c clears the overcapture flag without touching the event flag. A new overcapture wins over a clear in the same cycle.
- R8: `flag_clr` bit c clears the event flag. A capture or a generate in the same cycle wins over the clear.
- R9: `sw_gen` bit c sets the event flag without changing the capture register and without setting the overcapture flag. When it comes together with a capture, the flag is set once.
- R10: `irq[c]` is 1 exactly when flag c and `int_en[c]` are both 1. `dma_req[c]` is 1 exactly when flag c and `dma_en[c]` are both 1.
- R11: Set up as follows: channel 0 on its own pin with a rising edge, channel 1 on the other pin with a falling edge, and restart on channel 0. Then a steady PWM on pin 0 with a period of P clocks and a high time of H clocks gives `cap_val0` = P-1 and `cap_val1` = H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 2 | Asynchronous capture input pins |
| cnt_en | input | 1 | Counter enable |
| reload_val | input | CNT_W | Highest count before the wrap |
| restart_en | input | 1 | Clears the counter on the selected channel's capture |
| restart_src | input | 1 | Channel whose capture clears the counter |
| src_sel0 | input | 2 | Source select for channel 0 |
| src_sel1 | input | 2 | Source select for channel 1 |
| edge_pol | input | 2 | Per-channel edge select (0 rising, 1 falling) |
| int_en | input | 2 | Per-channel interrupt enable |
| dma_en | input | 2 | Per-channel DMA request enable |
| sw_gen | input | 2 | Per-channel software generate pulse |
| flag_clr | input | 2 | Per-channel write-one-to-clear for the event flag |
| ovr_clr | input | 2 | Per-channel write-one-to-clear for the overcapture flag |
| count | output | CNT_W | Counter value |
| cap_val0 | output | CNT_W | Channel 0 capture register |
| cap_val1 | output | CNT_W | Channel 1 capture register |
| cap_flag | output | 2 | Event flags |
| ovr_flag | output | 2 | Overcapture flags |
| irq | output | 2 | Interrupt requests |
| dma_req | output | 2 | DMA requests |

## Verification
A wrong synchronizer depth or a wrong edge polarity changes the capture value by a fixed number of counts. It also moves the flag rise by whole cycles, and every capture after the first one exposes this. A faulty restart or wrap path shows up on `count` one clock after the event. A flag or overcapture state that is set or cleared in the wrong cycle shows up at once on `cap_flag`, `ovr_flag`, `irq` and `dma_req`. The bench compares all of these every cycle, so a fault is normally reported within three clocks of the stimulus that exposes it.

// File: rtl/tcp_pkg.sv
`timescale 1ns/1ps
package tcp_pkg;
   typedef enum logic [1:0] {
      SRC_OFF  = 2'b00,
      SRC_OWN  = 2'b01,
      SRC_PEER = 2'b10,
      SRC_RSVD = 2'b11
   } src_sel_e;

   localparam int unsigned NCH = 2;
endpackage

// File: rtl/tcp_edge_sync.sv
`timescale 1ns/1ps
module tcp_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int unsigned TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("tcp_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[TOP-1:0], pin};
         prev_q <= sync_q[TOP];
      end
   end

   assign rise = sync_q[TOP] & ~prev_q;
   assign fall = ~sync_q[TOP] & prev_q;
endmodule

// File: rtl/tcp_counter.sv
`timescale 1ns/1ps
module tcp_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (restart)         cnt_q <= '0;
      else if (en) begin
         if (cnt_q == reload)   cnt_q <= '0;
         else                   cnt_q <= cnt_q + ONE;
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/tcp_channel.sv
`timescale 1ns/1ps
module tcp_channel #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             sw_gen,
   input  logic             flag_clr,
   input  logic             ovr_clr,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap_val,
   output logic             flag,
   output logic             ovr
);
   logic [CNT_W-1:0] cap_q;
   logic             flag_q;
   logic             ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= '0;
         flag_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (evt) cap_q <= count;

         if (evt || sw_gen)  flag_q <= 1'b1;
         else if (flag_clr)  flag_q <= 1'b0;

         if (evt && flag_q)  ovr_q <= 1'b1;
         else if (ovr_clr)   ovr_q <= 1'b0;
      end
   end

   assign cap_val = cap_q;
   assign flag    = flag_q;
   assign ovr     = ovr_q;
endmodule

// File: rtl/tmr_cap_pair.sv
`timescale 1ns/1ps
module tmr_cap_pair
   import tcp_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       pin_in,
   input  logic             cnt_en,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             restart_en,
   input  logic             restart_src,
   input  logic [1:0]       src_sel0,
   input  logic [1:0]       src_sel1,
   input  logic [1:0]       edge_pol,
   input  logic [1:0]       int_en,
   input  logic [1:0]       dma_en,
   input  logic [1:0]       sw_gen,
   input  logic [1:0]       flag_clr,
   input  logic [1:0]       ovr_clr,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap_val0,
   output logic [CNT_W-1:0] cap_val1,
   output logic [1:0]       cap_flag,
   output logic [1:0]       ovr_flag,
   output logic [1:0]       irq,
   output logic [1:0]       dma_req
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tmr_cap_pair: CNT_W must lie in 2..32");
   end

   logic [NCH-1:0] pin_rise;
   logic [NCH-1:0] pin_fall;
   logic [NCH-1:0] cap_evt;
   logic           restart_evt;
   logic [CNT_W-1:0] cap_arr [NCH];
   src_sel_e       sel_arr [NCH];

   assign sel_arr[0] = src_sel_e'(src_sel0);
   assign sel_arr[1] = src_sel_e'(src_sel1);

   for (genvar p = 0; p < NCH; p++) begin : g_pin
      tcp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pin_in[p]),
         .rise (pin_rise[p]),
         .fall (pin_fall[p])
      );
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int unsigned PEER = c ^ 1;
      logic own_edge;
      logic peer_edge;

      assign own_edge  = edge_pol[c] ? pin_fall[c]    : pin_rise[c];
      assign peer_edge = edge_pol[c] ? pin_fall[PEER] : pin_rise[PEER];

      always_comb begin
         unique case (sel_arr[c])
            SRC_OWN:  cap_evt[c] = own_edge;
            SRC_PEER: cap_evt[c] = peer_edge;
            default:  cap_evt[c] = 1'b0;
         endcase
      end

      tcp_channel #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (cap_evt[c]),
         .sw_gen  (sw_gen[c]),
         .flag_clr(flag_clr[c]),
         .ovr_clr (ovr_clr[c]),
         .count   (count),
         .cap_val (cap_arr[c]),
         .flag    (cap_flag[c]),
         .ovr     (ovr_flag[c])
      );
   end

   assign restart_evt = restart_en & cap_evt[restart_src];

   tcp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cnt_en),
      .restart(restart_evt),
      .reload (reload_val),
      .count  (count)
   );

   assign cap_val0 = cap_arr[0];
   assign cap_val1 = cap_arr[1];
   assign irq      = cap_flag & int_en;
   assign dma_req  = cap_flag & dma_en;
endmodule

// File: rtl/tcp_pair_chk.sv
`timescale 1ns/1ps
module tcp_pair_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cap_evt,
   input logic             restart_evt,
   input logic             cnt_en,
   input logic [CNT_W-1:0] reload_val,
   input logic [1:0]       sw_gen,
   input logic [1:0]       flag_clr,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cap_val0,
   input logic [CNT_W-1:0] cap_val1,
   input logic [1:0]       cap_flag,
   input logic [1:0]       ovr_flag
);
   // R3
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_evt |=> count == '0);

   // R2
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_evt && cnt_en && count == reload_val) |=> count == '0);

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_evt && !cnt_en) |=> $stable(count));

   // R6
   cap0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[0] |=> cap_val0 == $past(count));

   // R6
   cap1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt[1] |=> $stable(cap_val1));

   for (genvar c = 0; c < 2; c++) begin : g_flag
      // R9
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_evt[c] || sw_gen[c]) |=> cap_flag[c]);

      // R8
      flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_clr[c] && !cap_evt[c] && !sw_gen[c]) |=> !cap_flag[c]);

      // R7
      ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_evt[c] && cap_flag[c]) |=> ovr_flag[c]);

      // R7
      ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!cap_evt[c] && !ovr_flag[c]) |=> !ovr_flag[c]);
   end
endmodule

bind tmr_cap_pair tcp_pair_chk #(.CNT_W(CNT_W)) u_pair_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cap_evt    (cap_evt),
   .restart_evt(restart_evt),
   .cnt_en     (cnt_en),
   .reload_val (reload_val),
   .sw_gen     (sw_gen),
   .flag_clr   (flag_clr),
   .count      (count),
   .cap_val0   (cap_val0),
   .cap_val1   (cap_val1),
   .cap_flag   (cap_flag),
   .ovr_flag   (ovr_flag)
);

// File: tb/sim_tmr_cap_pair.sv
`timescale 1ns/1ps
module sim_tmr_cap_pair;
   localparam int unsigned W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] pin_in = '0;
   logic cnt_en = 1'b0;
   logic [W-1:0] reload_val = '0;
   logic restart_en = 1'b0;
   logic restart_src = 1'b0;
   logic [1:0] src_sel0 = '0, src_sel1 = '0, edge_pol = '0;
   logic [1:0] int_en = '0, dma_en = '0, sw_gen = '0, flag_clr = '0, ovr_clr = '0;
   logic [W-1:0] count, cap_val0, cap_val1;
   logic [1:0] cap_flag, ovr_flag, irq, dma_req;

   int n_chk = 0;
   int n_fail = 0;

   // reference state
   logic [1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
   logic [W-1:0] m_cnt = '0;
   logic [W-1:0] m_cap [2] = '{default: '0};
   logic [1:0] m_flag = '0, m_ovr = '0;

   always #4 clk = ~clk;

   tmr_cap_pair #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cnt_en(cnt_en),
      .reload_val(reload_val), .restart_en(restart_en), .restart_src(restart_src),
      .src_sel0(src_sel0), .src_sel1(src_sel1), .edge_pol(edge_pol),
      .int_en(int_en), .dma_en(dma_en), .sw_gen(sw_gen), .flag_clr(flag_clr),
      .ovr_clr(ovr_clr), .count(count), .cap_val0(cap_val0), .cap_val1(cap_val1),
      .cap_flag(cap_flag), .ovr_flag(ovr_flag), .irq(irq), .dma_req(dma_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic edge_of(input int p, input logic pol);
      return pol ? (~m_s2[p] & m_s3[p]) : (m_s2[p] & ~m_s3[p]);
   endfunction

   function automatic logic evt_of(input int c, input logic [1:0] sel);
      if (sel == 2'b01) return edge_of(c, edge_pol[c]);
      if (sel == 2'b10) return edge_of(c ^ 1, edge_pol[c]);
      return 1'b0;
   endfunction

   task automatic compare_all();
      chk("R2", 32'(count), 32'(m_cnt));
      chk("R6", 32'(cap_val0), 32'(m_cap[0]));
      chk("R6", 32'(cap_val1), 32'(m_cap[1]));
      chk("R8", 32'(cap_flag), 32'(m_flag));
      chk("R7", 32'(ovr_flag), 32'(m_ovr));
      chk("R10", 32'({irq, dma_req}), 32'({m_flag & int_en, m_flag & dma_en}));
   endtask

   // one clock: predict, advance, then compare away from the edge
   task automatic cycle();
      logic [1:0] ev;
      logic rs;
      ev[0] = evt_of(0, src_sel0);
      ev[1] = evt_of(1, src_sel1);
      rs = restart_en & ev[restart_src];
      @(posedge clk);
      for (int c = 0; c < 2; c++) begin
         if (ev[c]) m_cap[c] = m_cnt;
         if (ev[c] && m_flag[c]) m_ovr[c] = 1'b1;
         else if (ovr_clr[c]) m_ovr[c] = 1'b0;
         if (ev[c] || sw_gen[c]) m_flag[c] = 1'b1;
         else if (flag_clr[c]) m_flag[c] = 1'b0;
      end
      if (rs) m_cnt = '0;
      else if (cnt_en) m_cnt = (m_cnt == reload_val) ? '0 : m_cnt + 1'b1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      @(negedge clk);
      compare_all();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic clear_all();
      flag_clr = 2'b11; ovr_clr = 2'b11; cycle(); flag_clr = '0; ovr_clr = '0;
   endtask

   task automatic pwm(input int period, input int high, input int reps);
      for (int r = 0; r < reps; r++) begin
         pin_in[0] = 1'b1; run(high);
         pin_in[0] = 1'b0; run(period - high);
      end
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", 32'({count, cap_val0}), 32'h0);
      chk("R1", 32'(cap_val1), 32'h0);
      chk("R1", 32'({cap_flag, ovr_flag, irq, dma_req}), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: count and wrap at a small reload
      reload_val = 16'd5; cnt_en = 1'b1;
      run(6);
      chk("R2", 32'(count), 32'd0);
      run(3);
      cnt_en = 1'b0; run(4);
      chk("R2", 32'(count), 32'd3);

      // R11: PWM period and high time
      reload_val = 16'hFFFF; cnt_en = 1'b1;
      src_sel0 = 2'b01; src_sel1 = 2'b10; edge_pol = 2'b10;
      restart_en = 1'b1; restart_src = 1'b0;
      int_en = 2'b01; dma_en = 2'b10;
      pwm(40, 15, 4);
      run(3);
      chk("R11", 32'(cap_val0), 32'd39);
      chk("R11", 32'(cap_val1), 32'd14);
      // R7: unserviced flags have seen repeated captures
      chk("R7", 32'(ovr_flag), 32'b11);
      // R10: gating with one enable each
      chk("R10", 32'({irq, dma_req}), 32'b0110);

      // R7: overcapture clear leaves the event flag alone
      ovr_clr = 2'b01; cycle(); ovr_clr = '0;
      chk("R7", 32'({cap_flag, ovr_flag}), 32'b1110);
      clear_all();
      chk("R8", 32'(cap_flag), 32'b00);

      // R9: software generate keeps capture value and overcapture clear
      sw_gen = 2'b10; cycle(); sw_gen = 2'b10; cycle(); sw_gen = '0;
      chk("R9", 32'({cap_flag, ovr_flag}), 32'b1000);
      chk("R9", 32'(cap_val1), 32'd14);
      clear_all();

      // R4: source off gives no capture, reserved code too
      src_sel0 = 2'b00; src_sel1 = 2'b11; restart_en = 1'b0;
      pwm(12, 5, 3); run(3);
      chk("R4", 32'({cap_flag, ovr_flag}), 32'h0);
      chk("R4", 32'(cap_val0), 32'd39);

      // R5: falling edge on own pin, latency of two edges after first sample
      src_sel1 = 2'b01; edge_pol = 2'b10; cnt_en = 1'b0;
      pin_in[1] = 1'b1; run(4);
      pin_in[1] = 1'b0; cycle(); cycle();
      chk("R5", 32'(cap_flag[1]), 32'd0);
      cycle();
      chk("R5", 32'(cap_flag[1]), 32'd1);
      clear_all();

      // R3: restart applies while the counter is stopped
      restart_en = 1'b1; restart_src = 1'b1;
      pin_in[1] = 1'b1; run(4); pin_in[1] = 1'b0; run(4);
      chk("R3", 32'(count), 32'd0);
      clear_all();

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         if (($urandom % 8) == 0) pin_in[0] = ~pin_in[0];
         if (($urandom % 11) == 0) pin_in[1] = ~pin_in[1];
         sw_gen   = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
         flag_clr = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
         ovr_clr  = (($urandom % 9) == 0) ? 2'($urandom) : 2'b00;
         if (($urandom % 50) == 0) begin
            src_sel0 = 2'($urandom); src_sel1 = 2'($urandom);
            edge_pol = 2'($urandom); int_en = 2'($urandom); dma_en = 2'($urandom);
            restart_en = 1'($urandom); restart_src = 1'($urandom);
            cnt_en = (($urandom % 4) != 0);
         end
         if (($urandom % 400) == 0) reload_val = W'(3 + $urandom % 90);
         cycle();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule